// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider

This block divides one fast clock into two slow pulse trains, as the counting part of a frequency synthesizer loop. The feedback path counts input clocks in prescaler cycles that last either 6 or 7 clocks. A 4-bit swallow count chooses how many of those cycles are long. A 6-bit cycle count chooses how many prescaler cycles make one output period. A double control turns the 6/7 pair into 12/14. The result is a single feedback pulse once every N input clocks. A separate reference counter gives one pulse every R+1 clocks.

Each path holds its settings for a whole period. New settings are taken only at a period boundary, so a change never produces a short or a stretched period. The phase comparison and the oscillator that would consume these pulses are outside the block.

Top module: `swdiv_top`

## Requirements
- R1: With 1 <= A <= M and the double control at 0, the feedback period is N = 6*(M+1) + A input clocks. The first A prescaler cycles of a period last 7 clocks and the others last 6.
- R2: With A = 0 and the double control at 0, every prescaler cycle lasts 7 clocks, so N = 7*(M+1).
- R3: With A > M, every prescaler cycle of the period is a long one, so N = 7*(M+1).
- R4: With the double control at 1, the prescaler cycles last 12 or 14 clocks instead of 6 or 7, so N is twice the value given by R1 to R3 and is always even.
- R5: fb_pulse is high for exactly one clock per period. The register updated at the clock edge that ends the period drives it. The first pulse follows the N-th rising edge after reset is released.
- R6: The A, M and double values used for a period are the ones present during the clock in which the previous fb_pulse is high, or during the first clock after reset. Changes made at any other time have no effect on the running period.
- R7: ref_pulse has a period of R+1 input clocks, from 1 to 128. With R = 0 it stays high on every clock.
- R8: The R value for a reference period is taken in the clock in which the previous ref_pulse is high, or in the first clock after reset. Changes made at any other time have no effect on the running reference period.
- R9: While rst_n is low, fb_pulse and ref_pulse are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| a_in | input | 4 | Swallow count: the number of long prescaler cycles per period |
| m_in | input | 6 | Prescaler cycles per feedback period, minus one |
| dbl_in | input | 1 | 1 selects the 12/14 prescaler pair |
| r_in | input | 7 | Reference modulus minus one |
| fb_pulse | output | 1 | One-clock pulse per feedback period |
| ref_pulse | output | 1 | One-clock pulse per reference period |

## Verification
A corrupted prescaler count or cycle count shows up as a wrong spacing of fb_pulse. It becomes visible at the very next pulse, at most 896 clocks later. A setting register loaded at the wrong moment shows up one period late, as a period that matches the configuration before or after the one that should apply. The bench therefore changes the settings in the middle of each period, so that early loading produces a wrong interval. A fault in the reference counter appears within 128 clocks as a wrong ref_pulse spacing. In the R = 0 case it appears as a gap in the pulse train that should stay high.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  // Default field widths and short prescaler modulus.
  localparam int unsigned DEF_A_W    = 4;
  localparam int unsigned DEF_M_W    = 6;
  localparam int unsigned DEF_R_W    = 7;
  localparam int unsigned DEF_PRE_LO = 6;
endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
  parameter int unsigned PRE_LO = swdiv_pkg::DEF_PRE_LO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic long_cyc,
  input  logic dbl,
  output logic cyc_end
);
  localparam int unsigned CW = $clog2(2 * (PRE_LO + 1) + 1);

  logic [CW-1:0] cnt_q, cnt_d, len, last;

  always_comb begin
    len     = long_cyc ? CW'(PRE_LO + 1) : CW'(PRE_LO);
    last    = dbl ? ((len << 1) - CW'(1)) : (len - CW'(1));
    cyc_end = (cnt_q == last);
    cnt_d   = cyc_end ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/swdiv_ctrl.sv
module swdiv_ctrl #(
  parameter int unsigned A_W = swdiv_pkg::DEF_A_W,
  parameter int unsigned M_W = swdiv_pkg::DEF_M_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] a_in,
  input  logic [M_W-1:0] m_in,
  input  logic           dbl_in,
  input  logic           cyc_end,
  output logic           long_cyc,
  output logic           dbl_eff,
  output logic           pulse_q
);
  localparam int unsigned CMP_W = (A_W > M_W) ? A_W : M_W;

  logic           start_q;
  logic [M_W-1:0] kcnt_q, kcnt_d;
  logic [A_W-1:0] a_q, a_eff;
  logic [M_W-1:0] m_q, m_eff;
  logic           dbl_q;
  logic           period_end, cfg_en, kcnt_en;

  always_comb begin
    // Settings come straight from the inputs in a period's first clock.
    a_eff      = start_q ? a_in   : a_q;
    m_eff      = start_q ? m_in   : m_q;
    dbl_eff    = start_q ? dbl_in : dbl_q;
    long_cyc   = (a_eff == '0) || (CMP_W'(kcnt_q) < CMP_W'(a_eff));
    period_end = cyc_end && (kcnt_q == m_eff);
    cfg_en     = start_q;
    kcnt_en    = cyc_end;
    kcnt_d     = period_end ? '0 : kcnt_q + M_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      start_q <= period_end;
      pulse_q <= period_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       kcnt_q <= '0;
    else if (kcnt_en) kcnt_q <= kcnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      m_q   <= '0;
      dbl_q <= 1'b0;
    end else if (cfg_en) begin
      a_q   <= a_in;
      m_q   <= m_in;
      dbl_q <= dbl_in;
    end
  end
endmodule

// File: rtl/swdiv_refdiv.sv
module swdiv_refdiv #(
  parameter int unsigned R_W = swdiv_pkg::DEF_R_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [R_W-1:0] r_in,
  output logic           pulse_q
);
  logic           start_q, wrap, cfg_en;
  logic [R_W-1:0] r_q, r_eff, cnt_q, cnt_d;

  always_comb begin
    r_eff  = start_q ? r_in : r_q;
    wrap   = (cnt_q == r_eff);
    cfg_en = start_q;
    cnt_d  = wrap ? '0 : cnt_q + R_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      start_q <= wrap;
      pulse_q <= wrap;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      r_q <= '0;
    else if (cfg_en) r_q <= r_in;
  end
endmodule

// File: rtl/swdiv_top.sv
module swdiv_top #(
  parameter int unsigned A_W    = swdiv_pkg::DEF_A_W,
  parameter int unsigned M_W    = swdiv_pkg::DEF_M_W,
  parameter int unsigned R_W    = swdiv_pkg::DEF_R_W,
  parameter int unsigned PRE_LO = swdiv_pkg::DEF_PRE_LO
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] a_in,
  input  logic [M_W-1:0] m_in,
  input  logic           dbl_in,
  input  logic [R_W-1:0] r_in,
  output logic           fb_pulse,
  output logic           ref_pulse
);
  logic long_cyc, dbl_eff, cyc_end;

  swdiv_prescaler #(.PRE_LO(PRE_LO)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .long_cyc (long_cyc),
    .dbl      (dbl_eff),
    .cyc_end  (cyc_end)
  );

  swdiv_ctrl #(.A_W(A_W), .M_W(M_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_in     (a_in),
    .m_in     (m_in),
    .dbl_in   (dbl_in),
    .cyc_end  (cyc_end),
    .long_cyc (long_cyc),
    .dbl_eff  (dbl_eff),
    .pulse_q  (fb_pulse)
  );

  swdiv_refdiv #(.R_W(R_W)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .r_in    (r_in),
    .pulse_q (ref_pulse)
  );
endmodule

// File: rtl/swdiv_chk.sv
module swdiv_chk #(
  parameter int unsigned M_W    = swdiv_pkg::DEF_M_W,
  parameter int unsigned R_W    = swdiv_pkg::DEF_R_W,
  parameter int unsigned PRE_LO = swdiv_pkg::DEF_PRE_LO
) (
  input logic clk,
  input logic rst_n,
  input logic dbl_in,
  input logic fb_pulse,
  input logic ref_pulse
);
  localparam int unsigned FMIN = PRE_LO + 1;
  localparam int unsigned FMAX = 2 * (PRE_LO + 1) * (2 ** M_W);
  localparam int unsigned FGW  = $clog2(FMAX + 1) + 1;
  localparam int unsigned RMAX = 2 ** R_W;
  localparam int unsigned RGW  = R_W + 2;

  logic           fstart_q, dbl_cap_q;
  logic [FGW-1:0] fgap_q;
  logic [RGW-1:0] rgap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fstart_q  <= 1'b1;
      dbl_cap_q <= 1'b0;
      fgap_q    <= '0;
      rgap_q    <= '0;
    end else begin
      fstart_q <= fb_pulse;
      if (fstart_q) dbl_cap_q <= dbl_in;
      fgap_q <= fb_pulse ? FGW'(1) : ((&fgap_q) ? fgap_q : fgap_q + FGW'(1));
      rgap_q <= ref_pulse ? RGW'(1) : ((&rgap_q) ? rgap_q : rgap_q + RGW'(1));
    end
  end

  assert_fb_gap_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> (fgap_q >= FGW'(FMIN)));
  assert_fb_gap_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fgap_q <= FGW'(FMAX));
  assert_fb_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && dbl_cap_q) |-> !fgap_q[0]);
  assert_fb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);
  assert_ref_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rgap_q <= RGW'(RMAX));
endmodule

bind swdiv_top swdiv_chk #(.M_W(M_W), .R_W(R_W), .PRE_LO(PRE_LO)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dbl_in    (dbl_in),
  .fb_pulse  (fb_pulse),
  .ref_pulse (ref_pulse)
);

// File: tb/swdiv_top_tb.sv
module swdiv_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] a_in = '0;
  logic [5:0] m_in = '0;
  logic       dbl_in = 1'b0;
  logic [6:0] r_in = '0;
  logic       fb_pulse, ref_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit fb_done = 0;
  bit ref_done = 0;
  int    fq[$];
  string ftag[$];
  int    rq[$];
  string rtag[$];

  always #5 clk = ~clk;

  swdiv_top u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .m_in(m_in), .dbl_in(dbl_in),
    .r_in(r_in), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_n(input int a, input int m, input bit d);
    int base;
    base = (a == 0 || a > m) ? 7 * (m + 1) : 6 * (m + 1) + a;
    return d ? 2 * base : base;
  endfunction

  // Set feedback settings in the current clock and queue their period.
  task automatic fb_set(input int a, input int m, input bit d, input string tag);
    a_in = 4'(a); m_in = 6'(m); dbl_in = d;
    fq.push_back(exp_n(a, m, d));
    ftag.push_back(tag);
  endtask

  task automatic wait_fb();
    do @(negedge clk); while (!fb_pulse);
  endtask

  task automatic wait_ref();
    do @(negedge clk); while (!ref_pulse);
  endtask

  // Feedback driver: settings applied in the pulse clock, then disturbed mid-period (R6).
  task automatic fb_step(input int a, input int m, input bit d, input string tag);
    wait_fb();
    fb_set(a, m, d, tag);
    repeat (3) @(negedge clk);
    a_in = ~a_in; m_in = ~m_in; dbl_in = ~dbl_in;
  endtask

  task automatic ref_step(input int r, input int reps, input string tag);
    for (int i = 0; i < reps; i++) begin
      wait_ref();
      r_in = 7'(r);
      rq.push_back(r + 1);
      rtag.push_back(tag);
      if (r >= 4) begin
        repeat (2) @(negedge clk);
        r_in = ~r_in;   // R8: no effect mid-period
        wait_ref();
        r_in = 7'(r);
        rq.push_back(r + 1);
        rtag.push_back(tag);
      end
    end
  endtask

  // Feedback monitor (scoreboard)
  initial begin
    int gap = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) gap = 0;
      else begin
        gap++;
        if (fb_pulse) begin
          if (fq.size() > 0) begin
            int e; string t;
            e = fq.pop_front(); t = ftag.pop_front();
            check(gap == e, t, gap, e);
          end else if (!fb_done) check(1'b0, "R5 unexpected fb pulse", gap, 0);
          gap = 0;
        end
      end
    end
  end

  // Reference monitor (scoreboard)
  initial begin
    int gap = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) gap = 0;
      else begin
        gap++;
        if (ref_pulse) begin
          if (rq.size() > 0) begin
            int e; string t;
            e = rq.pop_front(); t = rtag.pop_front();
            check(gap == e, t, gap, e);
          end else if (!ref_done) check(1'b0, "R7 unexpected ref pulse", gap, 0);
          gap = 0;
        end
      end
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    fb_set(3, 5, 1'b0, "R5 R1 first period after reset");
    r_in = 7'd4;
    rq.push_back(5); rtag.push_back("R7 R8 first ref period");
    repeat (3) @(negedge clk);
    check(fb_pulse == 1'b0, "R9 fb low in reset", int'(fb_pulse), 0);
    check(ref_pulse == 1'b0, "R9 ref low in reset", int'(ref_pulse), 0);
    rst_n = 1'b1;
    fork
      begin
        fb_step(0, 5, 1'b0, "R2 A zero");
        fb_step(0, 0, 1'b0, "R2 minimum seven");
        fb_step(5, 5, 1'b0, "R1 A equals M");
        fb_step(9, 4, 1'b0, "R3 A above M");
        fb_step(1, 5, 1'b0, "R1 lowest 37");
        fb_step(15, 63, 1'b0, "R1 largest single");
        fb_step(2, 10, 1'b1, "R4 doubled 136");
        fb_step(0, 63, 1'b1, "R4 doubled maximum");
        fb_step(7, 20, 1'b0, "R6 back to single");
        fb_step(0, 9, 1'b1, "R4 doubled A zero");
        wait_fb();
        fb_done = 1;
      end
      begin
        ref_step(0, 6, "R7 modulus one");
        ref_step(1, 3, "R7 modulus two");
        ref_step(127, 1, "R7 R8 modulus 128");
        ref_step(9, 2, "R8 modulus ten");
        ref_step(5, 1, "R8 modulus six");
        wait_ref();
        ref_done = 1;
      end
    join
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule